// File: doc/BRIEF.md
# Scan/Select ADC Conversion Sequencer

This block drives an 8-bit successive-approximation converter across eight analog channels and keeps the last result of each of its eight conversion slots in a result register. An enable input starts and stops the sequencer. A mode input chooses how the lower four slots pick their channel. In scan mode, slot k converts channel k. In select mode, the lower four slots all convert one low channel, named by a 2-bit select field, which gives four consecutive samples of that channel. The upper four slots always convert their own channels.

One clock is one machine cycle. Every slot lasts 26 cycles: 2 sample cycles, then eight bit windows of 3 cycles each, tested MSB first. A full pass of eight slots therefore takes 208 cycles. The analog front end returns a single comparator bit for the trial code that the block presents. There is no per-conversion completion flag. Software reads the result registers whenever it needs them.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset every result register reads 0, `sample_o` is low and `dac_o` is 0.
- R2: While the sequencer is idle (enable low and no slot in progress), `sample_o` stays low, `dac_o` stays 0 and no result register changes.
- R3: Enable high while idle starts slot 0 on the next clock. Slots then run 0,1,...,7 and wrap to 0 while enable stays high. A restart from idle always begins at slot 0.
- R4: Each slot has `sample_o` high for its first 2 cycles, followed by eight 3-cycle bit windows: 26 cycles per slot and 208 cycles per pass.
- R5: During bit window n (n = 7 down to 0), `dac_o` equals the bits already kept plus bit n set. Bit n is kept when `cmp_i` is high in the last cycle of the window. `cmp_i` high means the input is at or above `dac_o`.
- R6: The final 8-bit code is written into the result register whose index equals the slot number, at the clock edge that ends the slot. No other register changes at that edge.
- R7: Slots 4 to 7 always select channel equal to the slot number, whatever the mode.
- R8: With `mode_i` = 0 (scan), slots 0 to 3 select channels 0 to 3 in turn.
- R9: With `mode_i` = 1 (select), slots 0 to 3 all select channel `sel_i`.
- R10: `mode_i` and `sel_i` are sampled only at the edge that starts a slot. `ch_o` does not change within a slot.
- R11: Enable low during a slot lets that slot finish and store its result. The sequencer then goes idle.
- R12: Inputs at the range ends convert exactly: an input of 0 gives 0x00 and an input of 255 gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one machine cycle per period |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run (1) or idle (0) |
| mode_i | input | 1 | 0 scan, 1 select for slots 0 to 3 |
| sel_i | input | 2 | Low channel used in select mode |
| cmp_i | input | 1 | Comparator: analog input at or above `dac_o` |
| ch_o | output | 3 | Channel for the current slot |
| sample_o | output | 1 | Sample phase of the current slot |
| dac_o | output | 8 | Trial code for the comparator, 0 outside bit windows |
| results_o | output | 64 | Eight result registers, register k at bits [8k+7:8k] |

## Verification
The hardest cases to reach are a mode or select change that arrives partway through a slot, and an enable drop in the middle of a pass. Both depend on where in the 26-cycle slot the input moves. The stimulus changes `mode_i` and `sel_i` mid-slot during a running pass. It also waits for a chosen cycle count inside a slot before dropping enable, and then counts the cycles until the sequencer goes quiet. A behavioural comparator built from per-channel input values answers each trial code, so every bit decision and every stored byte can be predicted from the input values.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic {
    MODE_SCAN   = 1'b0,
    MODE_SELECT = 1'b1
  } mode_e;
endpackage

// File: rtl/adc_slot_timer.sv
module adc_slot_timer #(
  parameter int unsigned NUM_SLOTS  = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SAMPLE_CYC = 2,
  parameter int unsigned BIT_CYC    = 3,
  localparam int unsigned SLOT_CYC  = SAMPLE_CYC + DATA_W * BIT_CYC,
  localparam int unsigned CNT_W     = $clog2(SLOT_CYC),
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS),
  localparam int unsigned BIT_W     = $clog2(DATA_W),
  localparam int unsigned SUB_W     = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic              busy_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              sample_o,
  output logic              conv_o,
  output logic [BIT_W-1:0]  bit_pos_o,
  output logic              decide_o,
  output logic              load_o,
  output logic              slot_end_o
);
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SUB_W-1:0]  sub_q;
  logic [BIT_W-1:0]  bitp_q;
  logic              in_samp;

  assign in_samp    = cnt_q < CNT_W'(SAMPLE_CYC);
  assign busy_o     = busy_q;
  assign slot_o     = slot_q;
  assign sample_o   = busy_q && in_samp;
  assign conv_o     = busy_q && !in_samp;
  assign bit_pos_o  = bitp_q;
  assign decide_o   = conv_o && (sub_q == SUB_W'(BIT_CYC - 1));
  assign slot_end_o = busy_q && (cnt_q == CNT_W'(SLOT_CYC - 1));
  assign load_o     = en_i && (!busy_q || slot_end_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      slot_q <= '0;
      sub_q  <= '0;
      bitp_q <= BIT_W'(DATA_W - 1);
    end else if (!busy_q) begin
      if (en_i) begin
        busy_q <= 1'b1;
        slot_q <= '0;
        cnt_q  <= '0;
        sub_q  <= '0;
        bitp_q <= BIT_W'(DATA_W - 1);
      end
    end else if (slot_end_o) begin
      cnt_q  <= '0;
      sub_q  <= '0;
      bitp_q <= BIT_W'(DATA_W - 1);
      if (en_i) slot_q <= (slot_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_q + SLOT_W'(1);
      else      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (!in_samp) begin
        if (sub_q == SUB_W'(BIT_CYC - 1)) begin
          sub_q  <= '0;
          bitp_q <= bitp_q - BIT_W'(1);
        end else begin
          sub_q <= sub_q + SUB_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned BIT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              conv_i,
  input  logic              decide_i,
  input  logic [BIT_W-1:0]  bit_pos_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] dac_o,
  output logic [DATA_W-1:0] code_o
);
  logic [DATA_W-1:0] code_q, code_d, trial;

  assign trial = {{(DATA_W-1){1'b0}}, 1'b1} << bit_pos_i;
  assign dac_o = conv_i ? (code_q | trial) : '0;

  always_comb begin
    code_d            = code_q;
    code_d[bit_pos_i] = cmp_i;
  end
  assign code_o = code_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       code_q <= '0;
    else if (clear_i)  code_q <= '0;
    else if (decide_i) code_q <= code_d;
  end
endmodule

// File: rtl/adc_chan_map.sv
module adc_chan_map
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH    = 8,
  parameter int unsigned SEL_SLOTS = 4,
  localparam int unsigned CH_W     = $clog2(NUM_CH),
  localparam int unsigned SEL_W    = $clog2(SEL_SLOTS)
) (
  input  logic [CH_W-1:0]  slot_i,
  input  mode_e            mode_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CH_W-1:0]  ch_o
);
  logic low_slot;
  assign low_slot = slot_i < CH_W'(SEL_SLOTS);
  assign ch_o = (low_slot && mode_i == MODE_SELECT) ? CH_W'(sel_i) : slot_i;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [SLOT_W-1:0]        slot_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [NUM_CH*DATA_W-1:0] results_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (wr_i && slot_i == SLOT_W'(g))      q <= data_i;
    end
    assign results_o[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned SEL_SLOTS  = 4,
  parameter int unsigned SAMPLE_CYC = 2,
  parameter int unsigned BIT_CYC    = 3,
  localparam int unsigned CH_W      = $clog2(NUM_CH),
  localparam int unsigned SEL_W     = $clog2(SEL_SLOTS),
  localparam int unsigned BIT_W     = $clog2(DATA_W)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     mode_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic                     cmp_i,
  output logic [CH_W-1:0]          ch_o,
  output logic                     sample_o,
  output logic [DATA_W-1:0]        dac_o,
  output logic [NUM_CH*DATA_W-1:0] results_o
);
  logic             busy, conv, decide, load, slot_end;
  logic [CH_W-1:0]  slot;
  logic [BIT_W-1:0] bit_pos;
  logic [DATA_W-1:0] code;
  mode_e            mode_q;
  logic [SEL_W-1:0] sel_q;

  adc_slot_timer #(
    .NUM_SLOTS(NUM_CH), .DATA_W(DATA_W),
    .SAMPLE_CYC(SAMPLE_CYC), .BIT_CYC(BIT_CYC)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .busy_o(busy), .slot_o(slot), .sample_o(sample_o), .conv_o(conv),
    .bit_pos_o(bit_pos), .decide_o(decide), .load_o(load), .slot_end_o(slot_end)
  );

  // mode and select held for a whole slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SCAN;
      sel_q  <= '0;
    end else if (load) begin
      mode_q <= mode_e'(mode_i);
      sel_q  <= sel_i;
    end
  end

  adc_chan_map #(.NUM_CH(NUM_CH), .SEL_SLOTS(SEL_SLOTS)) u_map (
    .slot_i(slot), .mode_i(mode_q), .sel_i(sel_q), .ch_o(ch_o)
  );

  adc_sar_reg #(.DATA_W(DATA_W)) u_sar (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(slot_end || !busy),
    .conv_i(conv), .decide_i(decide), .bit_pos_i(bit_pos), .cmp_i(cmp_i),
    .dac_o(dac_o), .code_o(code)
  );

  adc_result_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(slot_end), .slot_i(slot),
    .data_i(code), .results_o(results_o)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_CH    = 8,
  parameter int unsigned SEL_SLOTS = 4,
  localparam int unsigned CH_W     = $clog2(NUM_CH)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     busy_i,
  input logic [CH_W-1:0]          slot_i,
  input logic                     slot_end_i,
  input logic                     sample_i,
  input logic [CH_W-1:0]          ch_i,
  input logic [DATA_W-1:0]        dac_i,
  input logic [NUM_CH*DATA_W-1:0] results_i
);
  logic [NUM_CH*DATA_W-1:0] prev_q;
  logic [NUM_CH-1:0]        chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= results_i;
  end
  for (genvar k = 0; k < NUM_CH; k++) begin : g_chg
    assign chg[k] = results_i[k*DATA_W +: DATA_W] != prev_q[k*DATA_W +: DATA_W];
  end

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!sample_i && dac_i == '0));
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(results_i));
  p_sample_no_dac_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> dac_i == '0);
  p_msb_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sample_i) |-> dac_i == {1'b1, {(DATA_W-1){1'b0}}});
  p_single_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chg));
  p_upper_fixed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && slot_i >= CH_W'(SEL_SLOTS)) |-> ch_i == slot_i);
  p_ch_steady_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && !$past(slot_end_i)) |-> $stable(ch_i));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(
  .DATA_W(DATA_W), .NUM_CH(NUM_CH), .SEL_SLOTS(SEL_SLOTS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .slot_i(slot),
  .slot_end_i(slot_end), .sample_i(sample_o), .ch_i(ch_o),
  .dac_i(dac_o), .results_i(results_o)
);

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, mode = 1'b0;
  logic [1:0]  sel = '0;
  logic        cmp;
  logic [2:0]  ch;
  logic        sample;
  logic [7:0]  dac;
  logic [63:0] results;
  int ain [8];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // analog front end: comparator on per-channel input values
  assign cmp = ain[ch] >= int'(dac);

  adc_scan_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .sel_i(sel),
    .cmp_i(cmp), .ch_o(ch), .sample_o(sample), .dac_o(dac), .results_o(results)
  );

  // reference model
  int m_busy, m_slot, m_cnt, m_mode, m_sel;
  int m_res [8];

  function automatic int mchan(int s, int md, int sl);
    return (s < 4 && md != 0) ? sl : s;
  endfunction

  function automatic int res_of(int k);
    return int'(results[k*8 +: 8]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_slot = 0; m_cnt = 0; m_mode = 0; m_sel = 0;
      foreach (m_res[k]) m_res[k] = 0;
    end else if (m_busy == 0) begin
      if (en) begin
        m_busy = 1; m_slot = 0; m_cnt = 0; m_mode = int'(mode); m_sel = int'(sel);
      end
    end else if (m_cnt == 25) begin
      m_res[m_slot] = ain[mchan(m_slot, m_mode, m_sel)];
      if (en) begin
        m_slot = (m_slot + 1) % 8; m_cnt = 0; m_mode = int'(mode); m_sel = int'(sel);
      end else m_busy = 0;
    end else m_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    int exp_dac, v, b;
    exp_dac = 0;
    if (m_busy != 0 && m_cnt >= 2) begin
      b = 7 - (m_cnt - 2) / 3;
      v = ain[mchan(m_slot, m_mode, m_sel)];
      exp_dac = ((v >> (b + 1)) << (b + 1)) | (1 << b);
    end
    chk(sample == (m_busy != 0 && m_cnt < 2), "R4 sample phase", int'(sample),
        int'(m_busy != 0 && m_cnt < 2));
    chk(int'(dac) == exp_dac, "R5 trial code", int'(dac), exp_dac);
    if (m_busy != 0)
      chk(int'(ch) == mchan(m_slot, m_mode, m_sel),
          (m_slot >= 4) ? "R7 upper channel" : (m_mode != 0 ? "R9 select channel" : "R8 scan channel"),
          int'(ch), mchan(m_slot, m_mode, m_sel));
    for (int k = 0; k < 8; k++)
      chk(res_of(k) == m_res[k], "R6 result register", res_of(k), m_res[k]);
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int snap [8];
    int n;
    ain = '{0, 255, 128, 127, 53, 202, 1, 254};
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    chk(sample == 1'b0, "R1 reset sample", int'(sample), 0);
    chk(dac == 8'd0, "R1 reset dac", int'(dac), 0);
    chk(results == 64'd0, "R1 reset results", int'(results != 0), 0);

    // R2 idle
    for (int i = 0; i < 10; i++) begin
      cycles(1);
      chk(sample == 1'b0 && dac == 8'd0, "R2 idle quiet", int'(sample), 0);
    end

    // R3 R8 R12 scan passes
    en = 1'b1; mode = 1'b0;
    cycles(2 * 208 + 5);
    for (int k = 0; k < 8; k++) chk(res_of(k) == ain[k], "R3 R8 scan pass", res_of(k), ain[k]);
    chk(res_of(0) == 0, "R12 zero input", res_of(0), 0);
    chk(res_of(1) == 255, "R12 full-scale input", res_of(1), 255);

    // R10 mid-slot mode change, R9 select
    while (m_cnt != 12) cycles(1);
    mode = 1'b1; sel = 2'd2;
    cycles(1);
    chk(int'(ch) == mchan(m_slot, 0, 0), "R10 channel held mid-slot", int'(ch), mchan(m_slot, 0, 0));
    cycles(208 + 30);
    for (int k = 0; k < 4; k++) chk(res_of(k) == ain[2], "R9 select sel=2", res_of(k), ain[2]);
    sel = 2'd3;
    cycles(208 + 30);
    for (int k = 0; k < 4; k++) chk(res_of(k) == ain[3], "R9 select sel=3", res_of(k), ain[3]);
    for (int k = 4; k < 8; k++) chk(res_of(k) == ain[k], "R7 upper slots in select", res_of(k), ain[k]);

    // R11 stop mid-slot
    while (m_cnt != 10) cycles(1);
    en = 1'b0;
    n = 0;
    while (sample || dac != 8'd0 || m_busy != 0) begin
      cycles(1); n++;
      if (n > 40) break;
    end
    chk(n == 16, "R11 slot finishes then idles", n, 16);
    for (int k = 0; k < 8; k++) snap[k] = res_of(k);
    ain[0] = 90; ain[1] = 17;
    for (int i = 0; i < 40; i++) begin
      cycles(1);
      chk(sample == 1'b0 && dac == 8'd0, "R2 R11 quiet after stop", int'(sample), 0);
    end
    for (int k = 0; k < 8; k++) chk(res_of(k) == snap[k], "R2 results held", res_of(k), snap[k]);

    // R3 restart at slot 0
    mode = 1'b0; en = 1'b1;
    cycles(27);
    chk(res_of(0) == 90, "R3 restart slot 0", res_of(0), 90);
    chk(res_of(1) == snap[1], "R3 slot 1 not yet", res_of(1), snap[1]);
    cycles(30);
    chk(res_of(1) == 17, "R3 second slot", res_of(1), 17);
    cycles(5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule